// File: doc/BRIEF.md
# Supply and Pushbutton Reset Generator

This block produces the processor reset for a board from two sources: a supply-good flag that an external comparator has already digitized and made synchronous, and a raw active-low pushbutton. A bad supply forces reset at once. When the last cause goes away, reset is stretched by a fixed hold interval before it is released. A supply dip or a button press during that interval starts the interval again from its full length.

The pushbutton passes through a two-flop synchronizer and a debouncer before it can act. Time is kept with a millisecond tick divided down from the system clock, so every interval is set in milliseconds and scales with one clock parameter. The reset is driven in both polarities. A one-cycle pulse marks the release, so a downstream timer such as a watchdog can start counting from it.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok_i` is 0, `sys_rst_o` is 1 from the first clock edge that samples the 0 onward.
- R2: After the last reset cause clears, `sys_rst_o` stays 1 for at least HOLD_MS ms (HOLD_MS·CLKS_PER_MS cycles) and drops within HOLD_MS+1 ms plus two cycles.
- R3: While `rst_ni` is 0, `sys_rst_o` is 1, `sys_rst_no` is 0 and `rel_pulse_o` is 0; after `rst_ni` rises, release follows only the R2 hold after the supply is good.
- R4: `pbtn_ni` is active low and is acted on only after it has been stable low for DEBOUNCE_MS ticks; a low pulse shorter than one ms has no effect on the reset outputs.
- R5: An accepted press asserts `sys_rst_o`, and the hold interval starts only once the button has been accepted as released (stable high for DEBOUNCE_MS ticks).
- R6: `sys_rst_no` is always the inverse of `sys_rst_o`.
- R7: `rel_pulse_o` is 1 for exactly one cycle, the first cycle in which `sys_rst_o` is 0 after being 1, and 0 otherwise.
- R8: A supply dip or an accepted press during the hold interval restarts the full hold, measured from the moment that cause clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | 1 when the monitored supply is within tolerance |
| pbtn_ni | input | 1 | Raw pushbutton, active low, asynchronous |
| sys_rst_o | output | 1 | Processor reset, active high |
| sys_rst_no | output | 1 | Processor reset, active low |
| rel_pulse_o | output | 1 | One-cycle pulse on reset release |

## Verification
The hardest state to reach is a restart of the hold interval from its middle, since the interval only exists after a cause has cleared and before the counter expires. The stimulus first lets the supply recover, waits part of the interval, then drops the supply for a single cycle or presses the button long enough to pass the debouncer, and measures the release time from that second clearing. Bouncing is reached with a low pulse shorter than one tick period, which must leave the outputs untouched.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    typedef enum logic [1:0] {
        PH_FORCE = 2'd0,
        PH_HOLD  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rstgen_tick.sv
module rstgen_tick #(
    parameter int unsigned CLKS_PER_MS = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned W = rstgen_pkg::cnt_width(CLKS_PER_MS);
    localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tick;
    } tick_t;

    tick_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = (st_q.cnt == LAST);
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/rstgen_debounce.sv
module rstgen_debounce #(
    parameter int unsigned DEB_TICKS = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic pbtn_ni,
    output logic pressed_o
);
    localparam int unsigned W = rstgen_pkg::cnt_width(DEB_TICKS + 1);
    localparam logic [W-1:0] LAST = W'(DEB_TICKS - 1);

    typedef struct packed {
        logic [1:0]   sync;
        logic         pressed;
        logic [W-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;
    logic raw_low;

    assign raw_low = ~st_q.sync[1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pbtn_ni};
        if (raw_low == st_q.pressed) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == LAST) begin
                st_d.pressed = ~st_q.pressed;
                st_d.cnt     = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sync    <= 2'b11;
            st_q.pressed <= 1'b0;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pressed_o = st_q.pressed;
endmodule

// File: rtl/rstgen_hold.sv
module rstgen_hold #(
    parameter int unsigned HOLD_MS = 130
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic supply_ok_i,
    input  logic pressed_i,
    output logic rst_active_o,
    output logic rel_pulse_o
);
    import rstgen_pkg::*;

    localparam int unsigned W = cnt_width(HOLD_MS + 1);
    localparam logic [W-1:0] LAST = W'(HOLD_MS);

    typedef struct packed {
        phase_e       ph;
        logic [W-1:0] cnt;
        logic         pulse;
    } hold_t;

    hold_t st_d, st_q;
    logic  cause;

    assign cause = ~supply_ok_i | pressed_i;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (cause) begin
            st_d.ph  = PH_FORCE;
            st_d.cnt = '0;
        end else begin
            unique case (st_q.ph)
                PH_FORCE: begin
                    st_d.ph  = PH_HOLD;
                    st_d.cnt = '0;
                end
                PH_HOLD: begin
                    if (tick_i) begin
                        if (st_q.cnt == LAST) begin
                            st_d.ph    = PH_RUN;
                            st_d.pulse = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PH_RUN:  st_d.ph = PH_RUN;
                default: st_d.ph = PH_FORCE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ph    <= PH_FORCE;
            st_q.cnt   <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_active_o = (st_q.ph != PH_RUN);
    assign rel_pulse_o  = st_q.pulse;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned CLKS_PER_MS = 200000,
    parameter int unsigned DEBOUNCE_MS = 10,
    parameter int unsigned HOLD_MS     = 130
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic supply_ok_i,
    input  logic pbtn_ni,
    output logic sys_rst_o,
    output logic sys_rst_no,
    output logic rel_pulse_o
);
    logic tick;
    logic pressed;
    logic rst_active;

    rstgen_tick #(.CLKS_PER_MS(CLKS_PER_MS)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    rstgen_debounce #(.DEB_TICKS(DEBOUNCE_MS)) deb_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .pbtn_ni   (pbtn_ni),
        .pressed_o (pressed)
    );

    rstgen_hold #(.HOLD_MS(HOLD_MS)) hold_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .supply_ok_i  (supply_ok_i),
        .pressed_i    (pressed),
        .rst_active_o (rst_active),
        .rel_pulse_o  (rel_pulse_o)
    );

    assign sys_rst_o  = rst_active;
    assign sys_rst_no = ~rst_active;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int unsigned CLKS_PER_MS = 200000,
    parameter int unsigned HOLD_MS     = 130
) (
    input logic clk_i,
    input logic rst_ni,
    input logic supply_ok_i,
    input logic sys_rst_o,
    input logic sys_rst_no,
    input logic rel_pulse_o
);
    localparam logic [31:0] MIN_CYC = 32'(HOLD_MS * CLKS_PER_MS);

    logic [31:0] good_cyc;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            good_cyc <= '0;
        end else if (sys_rst_o && supply_ok_i) begin
            if (good_cyc != 32'hFFFF_FFFF) good_cyc <= good_cyc + 1'b1;
        end else begin
            good_cyc <= '0;
        end
    end

    AST_SUPPLY_BAD_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> sys_rst_o); // R1

    AST_HOLD_MINIMUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_o) |-> (good_cyc >= MIN_CYC)); // R2

    AST_POLARITY_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_no != sys_rst_o); // R6

    AST_PULSE_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rel_pulse_o |-> (!sys_rst_o && $past(sys_rst_o))); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rel_pulse_o |=> !rel_pulse_o); // R7

    AST_RELEASE_PULSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_o) |-> rel_pulse_o); // R7
endmodule

bind rst_supervisor rst_supervisor_chk #(
    .CLKS_PER_MS (CLKS_PER_MS),
    .HOLD_MS     (HOLD_MS)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .sys_rst_o   (sys_rst_o),
    .sys_rst_no  (sys_rst_no),
    .rel_pulse_o (rel_pulse_o)
);

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;
    localparam int unsigned CPM  = 4;
    localparam int unsigned DEB  = 3;
    localparam int unsigned HOLD = 10;
    localparam int MIN_REL = HOLD * CPM;
    localparam int MAX_REL = (HOLD + 1) * CPM + 2;

    typedef struct packed {
        logic        sup;
        logic        btn;
        logic [15:0] cyc;
        logic        exp_rst;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 16'd20, 1'b1},  // R1 R3 supply bad after power-on
        '{1'b1, 1'b1, 16'd30, 1'b1},  // R2 still inside hold
        '{1'b1, 1'b1, 16'd30, 1'b0},  // R2 released
        '{1'b0, 1'b1, 16'd5,  1'b1},  // R1 supply dip
        '{1'b1, 1'b1, 16'd60, 1'b0},  // R2 released again
        '{1'b1, 1'b0, 16'd2,  1'b0},  // R4 short bounce, not yet acted on
        '{1'b1, 1'b1, 16'd60, 1'b0},  // R4 bounce ignored
        '{1'b1, 1'b0, 16'd20, 1'b1},  // R5 press accepted
        '{1'b1, 1'b1, 16'd30, 1'b1},  // R5 hold waits for debounced release
        '{1'b1, 1'b1, 16'd40, 1'b0}   // R5 released
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup = 1'b0;
    logic btn_n = 1'b1;
    logic sys_rst, sys_rst_n, rel_pulse;

    int tests = 0;
    int fails = 0;
    int cyc_total = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rst_supervisor #(
        .CLKS_PER_MS (CPM),
        .DEBOUNCE_MS (DEB),
        .HOLD_MS     (HOLD)
    ) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .supply_ok_i (sup),
        .pbtn_ni     (btn_n),
        .sys_rst_o   (sys_rst),
        .sys_rst_no  (sys_rst_n),
        .rel_pulse_o (rel_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        tests++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic chk_rst(input string req, input logic exp);
        chk(req, int'(sys_rst), int'(exp));
        chk("R6 polarity", int'(sys_rst_n), int'(!exp));
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts cycles until reset drops, and release pulses seen meanwhile
    task automatic measure(output int n, output int pulses);
        n = 0;
        pulses = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n++;
            if (rel_pulse) pulses++;
            if (!sys_rst) break;
        end
        @(negedge clk);
        if (rel_pulse) pulses++;
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 20000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, p;
        wait_cyc(3);
        chk_rst("R3 reset state", 1'b1);
        chk("R3 pulse low in reset", int'(rel_pulse), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            sup   = VECS[v].sup;
            btn_n = VECS[v].btn;
            wait_cyc(int'(VECS[v].cyc));
            chk_rst($sformatf("R1/R2/R4/R5 vector %0d", v), VECS[v].exp_rst);
        end

        // R1: drop is seen one edge later
        sup = 1'b0;
        wait_cyc(1);
        chk_rst("R1 immediate assert", 1'b1);
        wait_cyc(5);
        sup = 1'b1;
        measure(n, p);
        chk_range("R2 hold length", n, MIN_REL, MAX_REL);
        chk("R7 single release pulse", p, 1);

        // R8: supply dip inside the hold restarts it
        sup = 1'b0;
        wait_cyc(3);
        sup = 1'b1;
        wait_cyc(30);
        chk_rst("R8 still held", 1'b1);
        sup = 1'b0;
        wait_cyc(1);
        sup = 1'b1;
        measure(n, p);
        chk_range("R8 restart after dip", n, MIN_REL, MAX_REL);
        chk("R7 pulse after restart", p, 1);

        // R8: accepted press inside the hold restarts it after release
        sup = 1'b0;
        wait_cyc(3);
        sup = 1'b1;
        wait_cyc(20);
        btn_n = 1'b0;
        wait_cyc(20);
        btn_n = 1'b1;
        measure(n, p);
        chk_range("R8 R5 restart after press", n, MIN_REL + 2, MAX_REL + (DEB + 1) * CPM + 2);

        // R4: sub-tick bounce while running does nothing
        btn_n = 1'b0;
        wait_cyc(2);
        btn_n = 1'b1;
        wait_cyc(30);
        chk_rst("R4 bounce while running", 1'b0);
        chk("R7 no pulse while running", int'(rel_pulse), 0);

        // R3: reset in the middle of run restarts from power-on
        rst_n = 1'b0;
        wait_cyc(2);
        chk_rst("R3 reset asserted", 1'b1);
        rst_n = 1'b1;
        measure(n, p);
        chk_range("R3 R2 power-on hold", n, MIN_REL, MAX_REL);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule